// File: doc/BRIEF.md
# Request-Triggered Burst Sequencer

This block runs one fixed-length data burst for each single-cycle request pulse. When it is idle and sees a request, it waits one lead cycle and then raises its data-enable strobe for a set number of cycles. During the burst it presents a payload word that it captured at the start. A one-cycle end-of-transfer flag marks the end of the burst. A parameter places that flag either in the cycle after the strobe drops or in the last strobe cycle.

After the burst the sequencer stays busy until a one-cycle acknowledge pulse arrives. Any request that comes while it is busy is dropped and is not queued. The block is meant to sit between a simple requester and a consumer that acknowledges each transfer.

Top module: `req_burst_ctrl`

## Requirements
- R1: While `rst_n` is low (asynchronous assertion), `data_en_o`, `eot_o` and `data_o` are 0, the sequencer returns to idle, and a request seen during reset starts no burst.
- R2: A request starts a burst only when the sequencer is idle. A request that arrives during the lead cycle, the burst, the flag cycle or the acknowledge wait is ignored and is not remembered afterwards.
- R3: `data_en_o` rises exactly two clock cycles after the edge at which an accepted request is sampled.
- R4: `data_en_o` stays high for exactly `BURST_LEN` consecutive cycles per burst, with `BURST_LEN` >= 1 (default 4).
- R5: `data_o` takes the value of `data_i` sampled at the clock edge where `data_en_o` rises. It stays stable for every cycle in which `data_en_o` is high, and keeps that value until the next capture.
- R6: With `EOT_MODE` = 0, `eot_o` is high in the first cycle after `data_en_o` falls. With `EOT_MODE` = 1, `eot_o` is high in the final cycle in which `data_en_o` is high.
- R7: `eot_o` is high for exactly one cycle per burst.
- R8: After the flag, the sequencer waits for `ack_i`, and only this wait state samples it. An acknowledge during the burst is ignored. A request is accepted again from the cycle after the acknowledge edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset, asynchronous assertion |
| req_i | input | 1 | Single-cycle burst request |
| ack_i | input | 1 | Single-cycle transfer acknowledge |
| data_i | input | DATA_W | Payload word, sampled at burst start |
| data_en_o | output | 1 | Data-enable strobe |
| eot_o | output | 1 | End-of-transfer flag |
| data_o | output | DATA_W | Held payload word |

## Verification
On every cycle, the assertions check the two-cycle start latency, that the payload holds while the strobe is high, where the flag sits relative to the falling strobe in the chosen mode, that the flag lasts one cycle, and that the sequencer stays in the acknowledge wait until an acknowledge arrives. Other properties only show up across a whole transaction, so only the bench's scenarios can demonstrate them. These are the exact burst length, that dropped requests are not queued, that an acknowledge during a burst has no effect, and how the block recovers from a reset in the middle of a burst. The bench runs both flag placements side by side on the same stimulus.

// File: rtl/req_burst_pkg.sv
package req_burst_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_LEAD  = 3'd1,
    ST_BURST = 3'd2,
    ST_TAIL  = 3'd3,
    ST_ACKW  = 3'd4
  } bst_state_e;
endpackage

// File: rtl/req_burst_fsm.sv
module req_burst_fsm
  import req_burst_pkg::*;
#(
  parameter int BURST_LEN = 4,
  parameter int EOT_MODE  = 0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_i,
  input  logic       ack_i,
  output bst_state_e st_o,
  output logic       last_o
);
  localparam int CNT_W = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BURST_LEN - 1);

  bst_state_e       st_q, st_nxt;
  logic [CNT_W-1:0] cnt_q, cnt_nxt;
  logic             cnt_en, last;

  assign last   = (cnt_q == CNT_LAST);
  assign cnt_en = (st_q == ST_BURST);
  assign cnt_nxt = last ? '0 : cnt_q + CNT_W'(1);

  always_comb begin
    st_nxt = st_q;
    unique case (st_q)
      ST_IDLE:  if (req_i) st_nxt = ST_LEAD;
      ST_LEAD:  st_nxt = ST_BURST;
      ST_BURST: if (last) st_nxt = (EOT_MODE == 0) ? ST_TAIL : ST_ACKW;
      ST_TAIL:  st_nxt = ST_ACKW;
      ST_ACKW:  if (ack_i) st_nxt = ST_IDLE;
      default:  st_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_nxt;
  end

  assign st_o   = st_q;
  assign last_o = last;

  // R3
  lead_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && req_i) |-> ##2 (st_q == ST_BURST && cnt_q == '0));

  // R8
  ack_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_ACKW && !ack_i) |=> (st_q == ST_ACKW));

  // R2
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != ST_IDLE && st_q != ST_ACKW) |=> (st_q != ST_IDLE));
endmodule

// File: rtl/req_burst_out.sv
module req_burst_out
  import req_burst_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int EOT_MODE = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  bst_state_e        st_i,
  input  logic              last_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              data_en_o,
  output logic              eot_o,
  output logic [DATA_W-1:0] data_o
);
  logic [DATA_W-1:0] data_q;
  logic              cap_en;

  assign cap_en    = (st_i == ST_LEAD);
  assign data_en_o = (st_i == ST_BURST);

  generate
    if (EOT_MODE == 0) begin : g_eot_after
      assign eot_o = (st_i == ST_TAIL);
      logic unused_last;
      assign unused_last = last_i;
      // R6
      eot_after_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(data_en_o) |-> eot_o);
    end else begin : g_eot_last
      assign eot_o = (st_i == ST_BURST) && last_i;
      // R6
      eot_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(data_en_o) |-> $past(eot_o));
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      data_q <= '0;
    else if (cap_en) data_q <= data_i;
  end

  assign data_o = data_q;

  // R5
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_en_o && $past(data_en_o)) |-> $stable(data_o));

  // R7
  eot_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eot_o |=> !eot_o);
endmodule

// File: rtl/req_burst_ctrl.sv
module req_burst_ctrl
  import req_burst_pkg::*;
#(
  parameter int BURST_LEN = 4,
  parameter int DATA_W    = 8,
  parameter int EOT_MODE  = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic              ack_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              data_en_o,
  output logic              eot_o,
  output logic [DATA_W-1:0] data_o
);
  bst_state_e st;
  logic       last;

  req_burst_fsm #(.BURST_LEN(BURST_LEN), .EOT_MODE(EOT_MODE)) u_fsm (
    .clk    (clk),
    .rst_n  (rst_n),
    .req_i  (req_i),
    .ack_i  (ack_i),
    .st_o   (st),
    .last_o (last)
  );

  req_burst_out #(.DATA_W(DATA_W), .EOT_MODE(EOT_MODE)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .st_i      (st),
    .last_i    (last),
    .data_i    (data_i),
    .data_en_o (data_en_o),
    .eot_o     (eot_o),
    .data_o    (data_o)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |-> (!data_en_o && !eot_o && data_o == '0));
endmodule

// File: tb/sim_req_burst_ctrl.sv
module sim_req_burst_ctrl;
  localparam int BL = 4;
  localparam int DW = 8;
  localparam int NV = 6;
  // {payload[12:5], ack gap[4:1], stray req/ack[0]}
  localparam logic [12:0] VEC [NV] = '{
    {8'hA5, 4'd0, 1'b0}, {8'h3C, 4'd2, 1'b1}, {8'hFF, 4'd1, 1'b0},
    {8'h00, 4'd3, 1'b1}, {8'h81, 4'd0, 1'b1}, {8'h5E, 4'd5, 1'b0}
  };

  logic clk = 1'b0;
  logic rst_n, req, ack;
  logic [DW-1:0] din;
  logic en0, eot0, en1, eot1;
  logic [DW-1:0] d0, d1;
  int nchk = 0, nfail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  req_burst_ctrl #(.BURST_LEN(BL), .DATA_W(DW), .EOT_MODE(0)) u0 (
    .clk(clk), .rst_n(rst_n), .req_i(req), .ack_i(ack), .data_i(din),
    .data_en_o(en0), .eot_o(eot0), .data_o(d0));
  req_burst_ctrl #(.BURST_LEN(BL), .DATA_W(DW), .EOT_MODE(1)) u1 (
    .clk(clk), .rst_n(rst_n), .req_i(req), .ack_i(ack), .data_i(din),
    .data_en_o(en1), .eot_o(eot1), .data_o(d1));

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s: got %0h expected %0h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic idle_quiet(input int n, input string tag);
    for (int k = 0; k < n; k++) begin
      chk({tag, " en0"}, 32'(en0), 0);
      chk({tag, " en1"}, 32'(en1), 0);
      step();
    end
  endtask

  task automatic run_burst(input logic [DW-1:0] p, input int gap, input bit stray);
    req = 1'b1; din = ~p; step();
    req = 1'b0; din = p;
    chk("R3 lead en0", 32'(en0), 0); chk("R3 lead en1", 32'(en1), 0);
    step();
    for (int i = 0; i < BL; i++) begin
      din = p ^ 8'h5A; req = stray; ack = stray;
      chk("R3/R4 en0", 32'(en0), 1); chk("R4 en1", 32'(en1), 1);
      chk("R5 data0", 32'(d0), 32'(p)); chk("R5 data1", 32'(d1), 32'(p));
      chk("R6 eot0 in burst", 32'(eot0), 0);
      chk("R6 eot1 last", 32'(eot1), 32'(i == BL - 1));
      step();
    end
    req = 1'b0; ack = 1'b0;
    chk("R4 en0 fall", 32'(en0), 0); chk("R4 en1 fall", 32'(en1), 0);
    chk("R6 eot0 after", 32'(eot0), 1); chk("R7 eot1 once", 32'(eot1), 0);
    step();
    for (int g = 0; g < gap; g++) begin
      req = stray;
      chk("R7 eot0 once", 32'(eot0), 0); chk("R8 wait en0", 32'(en0), 0);
      chk("R8 wait en1", 32'(en1), 0);
      step();
    end
    req = 1'b0; ack = 1'b1;
    chk("R7 eot0 at ack", 32'(eot0), 0); chk("R5 data hold", 32'(d0), 32'(p));
    step();
    ack = 1'b0;
    if (stray) idle_quiet(3, "R2 no queue");
  endtask

  initial begin
    rst_n = 1'b0; req = 1'b1; ack = 1'b0; din = 8'hC3;
    step(); step(); step();
    chk("R1 reset en0", 32'(en0), 0); chk("R1 reset eot0", 32'(eot0), 0);
    chk("R1 reset data", 32'(d0), 0); chk("R1 reset en1", 32'(en1), 0);
    rst_n = 1'b1; req = 1'b0;
    idle_quiet(4, "R1 req in reset");

    for (int v = 0; v < NV; v++)
      run_burst(VEC[v][12:5], int'(VEC[v][4:1]), VEC[v][0]);

    // R8: back-to-back request right after an acknowledge
    run_burst(8'h12, 0, 1'b0);
    run_burst(8'h34, 0, 1'b0);

    // R8: no acknowledge means no new burst
    req = 1'b1; din = 8'h77; step(); req = 1'b0;
    for (int k = 0; k < BL + 3; k++) step();
    req = 1'b1; step(); req = 1'b0;
    idle_quiet(4, "R8 no ack");
    ack = 1'b1; step(); ack = 1'b0;
    run_burst(8'h9C, 1, 1'b0);

    // R1: reset in the middle of a burst
    req = 1'b1; din = 8'h00; step(); req = 1'b0; din = 8'h6B; step(); step();
    rst_n = 1'b0; #1;
    chk("R1 async en0", 32'(en0), 0); chk("R1 async data", 32'(d0), 0);
    chk("R1 async en1", 32'(en1), 0);
    step(); rst_n = 1'b1;
    idle_quiet(BL + 3, "R1 post reset");
    run_burst(8'hE1, 2, 1'b1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule